// File: doc/BRIEF.md
# Implication-based concurrent error checker

This block watches a vector of nets tapped out of a monitored logic block and raises an error whenever an invariant between two of those nets is broken. Each invariant pairs a trigger net with a trigger value and a target net with a target value. It states that whenever the trigger net carries its trigger value, the target net must carry its target value. The block reports a breach when the trigger net matches while the target net carries the complement of its target value. The invariants come from offline analysis of the monitored block. The two nets of a pair are usually two or more gate levels apart, so one pair can expose faults at several sites between them.

Every invariant has a run-time configuration: the two tap indices, the two values and an enable bit. Clearing enable bits removes invariants from the error flag, so the set in use can be trimmed to fit an area or power budget. The block gives a combinational flag for each invariant and one combined flag. It also keeps three pieces of registered state: a copy of the combined flag delayed by one cycle, a sticky flag, and a saturating count of the cycles with a breach. A synchronous clear input resets the sticky flag and the counter.

Top module: `impl_checker`

## Requirements
- R1: For each invariant k, viol_o[k] is 1 in the same cycle exactly when en_i[k] is 1, the tap at trigger index k (field k of trg_idx_i, IDX_W bits, invariant 0 in the least significant field) equals trg_val_i[k], and the tap at target index k (field k of tgt_idx_i) differs from tgt_val_i[k].
- R2: An invariant with en_i[k] = 0 never sets viol_o[k], err_o, err_q_o, sticky_o or cnt_o, whatever its taps and configuration.
- R3: err_o is 1 in the same cycle exactly when at least one bit of viol_o is 1.
- R4: err_q_o equals the value that err_o had in the previous cycle.
- R5: sticky_o becomes 1 on the clock edge after a cycle in which err_o is 1. It stays 1 until a cycle in which clr_i is 1. clr_i takes priority over a breach in the same cycle.
- R6: cnt_o increases by one on each clock edge after a cycle with err_o = 1 and clr_i = 0. It holds at 2^CNT_W-1 and never wraps.
- R7: A cycle with clr_i = 1 makes cnt_o zero on the next clock edge.
- R8: While rst_ni is low, and right after it is released, err_q_o, sticky_o and cnt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| taps_i | input | TAP_W | Values of the tapped nets |
| trg_idx_i | input | N_IMPL*IDX_W | Trigger tap index for each invariant |
| trg_val_i | input | N_IMPL | Trigger value for each invariant |
| tgt_idx_i | input | N_IMPL*IDX_W | Target tap index for each invariant |
| tgt_val_i | input | N_IMPL | Target value for each invariant |
| en_i | input | N_IMPL | Enable bit for each invariant |
| clr_i | input | 1 | Synchronous clear of the sticky flag and the counter |
| viol_o | output | N_IMPL | Breach flag for each invariant, combinational |
| err_o | output | 1 | OR of all breach flags, combinational |
| err_q_o | output | 1 | err_o delayed by one cycle |
| sticky_o | output | 1 | Latched breach flag |
| cnt_o | output | CNT_W | Saturating count of breach cycles |

## Verification
A wrong tap select, a wrong literal polarity or a lost enable bit shows up on viol_o and err_o in the same cycle as the tap pattern that exposes it. The bench compares both outputs against a model after every input change. Faults in the registered state show up one edge later. A counter that drops an increment or wraps stays off from that point on. A sticky flag that drops or ignores clr_i differs from the model on the next edge. Long error runs and a clear that coincides with a breach drive the counter and the sticky flag into their corner cases.

// File: rtl/impl_chk_pkg.sv
package impl_chk_pkg;
  // literal match: inverter only when the required value is 0
  function automatic logic lit_hit(input logic net, input logic want);
    return want ? net : ~net;
  endfunction
endpackage

// File: rtl/impl_cell.sv
module impl_cell #(
  parameter int TAP_W = 16,
  parameter int IDX_W = $clog2(TAP_W)
) (
  input  logic [TAP_W-1:0] taps_i,
  input  logic [IDX_W-1:0] trg_idx_i,
  input  logic             trg_val_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic             tgt_val_i,
  input  logic             en_i,
  output logic             viol_o
);
  import impl_chk_pkg::*;
  localparam int PAD_W = 2 ** IDX_W;

  logic [PAD_W-1:0] taps_pad;
  logic             trg_net, tgt_net;

  // out-of-range indices read as 0
  assign taps_pad = PAD_W'(taps_i);
  assign trg_net  = taps_pad[trg_idx_i];
  assign tgt_net  = taps_pad[tgt_idx_i];

  // breach: trigger literal true, target literal false
  assign viol_o = en_i & lit_hit(trg_net, trg_val_i) & lit_hit(tgt_net, ~tgt_val_i);
endmodule

// File: rtl/viol_or.sv
module viol_or #(
  parameter int N = 8
) (
  input  logic [N-1:0] viol_i,
  output logic         any_o
);
  assign any_o = |viol_i;
endmodule

// File: rtl/err_track.sv
module err_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             clr_i,
  output logic             err_q_o,
  output logic             sticky_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q_o  <= 1'b0;
      sticky_o <= 1'b0;
      cnt_o    <= '0;
    end else begin
      err_q_o <= err_i;
      if (clr_i) begin
        sticky_o <= 1'b0;
        cnt_o    <= '0;
      end else begin
        if (err_i) sticky_o <= 1'b1;
        if (err_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/impl_checker.sv
module impl_checker #(
  parameter int TAP_W  = 16,
  parameter int N_IMPL = 8,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = $clog2(TAP_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TAP_W-1:0]        taps_i,
  input  logic [N_IMPL*IDX_W-1:0] trg_idx_i,
  input  logic [N_IMPL-1:0]       trg_val_i,
  input  logic [N_IMPL*IDX_W-1:0] tgt_idx_i,
  input  logic [N_IMPL-1:0]       tgt_val_i,
  input  logic [N_IMPL-1:0]       en_i,
  input  logic                    clr_i,
  output logic [N_IMPL-1:0]       viol_o,
  output logic                    err_o,
  output logic                    err_q_o,
  output logic                    sticky_o,
  output logic [CNT_W-1:0]        cnt_o
);
  for (genvar k = 0; k < N_IMPL; k++) begin : g_cell
    impl_cell #(.TAP_W(TAP_W), .IDX_W(IDX_W)) u_cell (
      .taps_i    (taps_i),
      .trg_idx_i (trg_idx_i[k*IDX_W +: IDX_W]),
      .trg_val_i (trg_val_i[k]),
      .tgt_idx_i (tgt_idx_i[k*IDX_W +: IDX_W]),
      .tgt_val_i (tgt_val_i[k]),
      .en_i      (en_i[k]),
      .viol_o    (viol_o[k])
    );
  end

  viol_or #(.N(N_IMPL)) u_or (
    .viol_i (viol_o),
    .any_o  (err_o)
  );

  err_track #(.CNT_W(CNT_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_o),
    .clr_i    (clr_i),
    .err_q_o  (err_q_o),
    .sticky_o (sticky_o),
    .cnt_o    (cnt_o)
  );
endmodule

// File: rtl/impl_checker_sva.sv
module impl_checker_sva #(
  parameter int N_IMPL = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IMPL-1:0] en_i,
  input logic              clr_i,
  input logic [N_IMPL-1:0] viol_o,
  input logic              err_o,
  input logic              err_q_o,
  input logic              sticky_o,
  input logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (rst_ni) begin
      a_r2_disabled_quiet: assert ((viol_o & ~en_i) == '0);
    end
  end

  a_r4_err_q_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> err_q_o == $past(err_o));

  a_r5_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr_i) |=> sticky_o);

  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> sticky_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != CNT_MAX && !clr_i) |=> cnt_o == $past(cnt_o) + CNT_W'($past(err_o)));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0 && !sticky_o));
endmodule

bind impl_checker impl_checker_sva #(.N_IMPL(N_IMPL), .CNT_W(CNT_W)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .clr_i    (clr_i),
  .viol_o   (viol_o),
  .err_o    (err_o),
  .err_q_o  (err_q_o),
  .sticky_o (sticky_o),
  .cnt_o    (cnt_o)
);

// File: tb/impl_checker_tb.sv
`timescale 1ns/1ps
module impl_checker_tb;
  localparam int TAP_W  = 16;
  localparam int N_IMPL = 8;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = $clog2(TAP_W);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [TAP_W-1:0]        taps_i = '0;
  logic [N_IMPL*IDX_W-1:0] trg_idx_i = '0;
  logic [N_IMPL-1:0]       trg_val_i = '0;
  logic [N_IMPL*IDX_W-1:0] tgt_idx_i = '0;
  logic [N_IMPL-1:0]       tgt_val_i = '0;
  logic [N_IMPL-1:0]       en_i = '0;
  logic                    clr_i = 1'b0;
  logic [N_IMPL-1:0]       viol_o;
  logic                    err_o, err_q_o, sticky_o;
  logic [CNT_W-1:0]        cnt_o;

  impl_checker #(.TAP_W(TAP_W), .N_IMPL(N_IMPL), .CNT_W(CNT_W)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  int m_cnt = 0;
  bit m_sticky = 0, m_q = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N_IMPL-1:0] exp_viol();
    logic [N_IMPL-1:0] v = '0;
    for (int k = 0; k < N_IMPL; k++) begin
      int ai = int'(trg_idx_i[k*IDX_W +: IDX_W]);
      int ci = int'(tgt_idx_i[k*IDX_W +: IDX_W]);
      v[k] = en_i[k] && (taps_i[ai] == trg_val_i[k]) && (taps_i[ci] != tgt_val_i[k]);
    end
    return v;
  endfunction

  task automatic check_comb();
    logic [N_IMPL-1:0] v = exp_viol();
    chk("R1", viol_o, v);
    chk("R3", err_o, v != 0);
    for (int k = 0; k < N_IMPL; k++)
      if (!en_i[k]) chk("R2", viol_o[k], 0);
  endtask

  // one clock: update model from current inputs, then compare registered outputs
  task automatic step();
    bit e = (exp_viol() != 0);
    @(posedge clk_i);
    m_q = e;
    if (clr_i) begin
      m_sticky = 0; m_cnt = 0;
    end else begin
      if (e) m_sticky = 1;
      if (e && m_cnt < CMAX) m_cnt++;
    end
    #2;
    chk("R4", err_q_o, m_q);
    chk("R5", sticky_o, m_sticky);
    chk(clr_i ? "R7" : "R6", cnt_o, m_cnt);
  endtask

  task automatic set_cfg(input int k, input int ai, input bit av, input int ci, input bit cv, input bit en);
    trg_idx_i[k*IDX_W +: IDX_W] = IDX_W'(ai);
    tgt_idx_i[k*IDX_W +: IDX_W] = IDX_W'(ci);
    trg_val_i[k] = av;
    tgt_val_i[k] = cv;
    en_i[k] = en;
  endtask

  task automatic drive(input logic [TAP_W-1:0] t);
    taps_i = t;
    #1;
    check_comb();
  endtask

  initial begin
    #100000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R8: reset state
    taps_i = '1;
    set_cfg(0, 0, 1, 1, 0, 1);
    #30;
    chk("R8", err_q_o, 0); chk("R8", sticky_o, 0); chk("R8", cnt_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    taps_i = '0; #1;
    chk("R8", sticky_o, 0); chk("R8", cnt_o, 0);

    // R1: all four literal polarity combinations on invariant 0
    for (int av = 0; av < 2; av++)
      for (int cv = 0; cv < 2; cv++) begin
        set_cfg(0, 3, av[0], 9, cv[0], 1);
        for (int p = 0; p < 4; p++) begin
          @(negedge clk_i);
          drive(TAP_W'((p & 1) << 3) | TAP_W'(((p >> 1) & 1) << 9));
          step();
        end
      end

    // R2: disabled invariant with a breaching pattern
    set_cfg(0, 3, 1, 9, 1, 0);
    @(negedge clk_i); drive(TAP_W'(1 << 3)); step();
    chk("R2", err_o, 0);

    // R7: clear
    @(negedge clk_i); clr_i = 1'b1; drive('0); step();
    @(negedge clk_i); clr_i = 1'b0; drive('0); step();
    chk("R7", cnt_o, 0);

    // random configurations and taps
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      if (i % 50 == 0)
        for (int k = 0; k < N_IMPL; k++)
          set_cfg(k, $urandom_range(TAP_W-1), 1'($urandom), $urandom_range(TAP_W-1),
                  1'($urandom), 1'($urandom));
      clr_i = ($urandom_range(40) == 0);
      drive(TAP_W'($urandom));
      step();
    end

    // R6: saturation with a permanent breach
    @(negedge clk_i); clr_i = 1'b0;
    for (int k = 0; k < N_IMPL; k++) set_cfg(k, 0, 1, 1, 1, (k == 2));
    drive(TAP_W'(1));
    for (int i = 0; i < CMAX + 20; i++) step();
    chk("R6", cnt_o, CMAX);

    // R5/R7: clear beats a breach in the same cycle
    @(negedge clk_i); clr_i = 1'b1; drive(TAP_W'(1)); step();
    chk("R5", sticky_o, 0);
    @(negedge clk_i); clr_i = 1'b0; drive(TAP_W'(1)); step();
    chk("R5", sticky_o, 1);
    @(negedge clk_i); drive('0); step(); step();
    chk("R5", sticky_o, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule